// File: doc/BRIEF.md
# PWM Fault Lock Controller

This block produces a single pulse-width-modulated output from a free-running up-counter. It also holds a fault-lock stage that watches several asynchronous digital comparator outputs. Each comparator channel has its own two-bit lock mode. When an enabled channel sees a falling edge, the output is forced straight to an idle level. The polarity bit chooses that idle level.

The block has two lock flavours:

- **Hard lock** holds the output idle until software writes a release bit.
- **Soft lock** holds the output idle only until the counter next wraps. It also copies a pending duty value into the active duty register at the moment it triggers, so the next period runs with the new duty.

The counter keeps running through any lock, so soft-lock release always falls on a period boundary.

Software reaches the block through a small synchronous register port. It can write four registers and read them back through a combinational read mux:

| Address | Register |
|---|---|
| 0 | Active duty |
| 1 | Pending duty |
| 2 | Period |
| 3 | Control |

The control register fields are:

| Bits | Field |
|---|---|
| 0 | Polarity |
| 1 | Release (write-only) |
| 2k+3 : 2k+2 | Lock mode of channel k |

Top module: `pwmlock_top`

## Requirements
- R1: After reset, all four registers read 0 and `pwmOut` is 0.
- R2: When no lock is active, `pwmOut` has two phases. The counter steps 0, 1, …, P, 0, … where P is the period register (address 2). `pwmOut` equals polarity XOR (count < active duty).
- R3: A falling edge on a channel whose mode is 2'b01 or 2'b11 forces `pwmOut` to the polarity bit value. This takes effect no later than the second rising clock edge after the input goes low.
- R4: A channel in mode 2'b00 or 2'b10 ignores falling edges, and `pwmOut` keeps its normal waveform.
- R5: A hard lock (mode 2'b11) keeps `pwmOut` at the polarity level across any number of period wraps. A write to address 3 with bit 1 set ends the lock, and the normal waveform is back from the next cycle.
- R6: A soft lock trigger (mode 2'b01) loads the active duty register (address 0) with the pending duty value (address 1).
- R7: A soft lock ends when the counter wraps from P to 0. If the trigger lands in the same cycle as the wrap, the lock lasts to the following wrap.
- R8: Control bit 1 always reads back as 0. The other control bits read back as written.
- R9: When a hard-lock channel and a soft-lock channel trigger in the same cycle, only the hard lock takes effect. The active duty is not reloaded, and the lock survives a period wrap.
- R10: A rising edge on an enabled channel does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | BUS_W | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | BUS_W | Register read data (combinational) |
| cmpIn | input | NUM_CH | Asynchronous comparator outputs, idle high |
| pwmOut | output | 1 | PWM output |

## Verification
A wrong internal state shows up at `pwmOut` within one or two cycles:

- A stuck lock flag leaves the output frozen at the polarity level past the period wrap where it should have resumed.
- A missed trigger lets the waveform continue where it should have gone idle.

A wrong reload is visible at once on the active-duty readback, and after release in the pulse width. The bench tracks the counter phase arithmetically and sweeps period, duty and polarity. It triggers soft locks at every counter phase so that the wrap-coincident case is reached.

// File: rtl/pwmlock_pkg.sv
package pwmlock_pkg;

  typedef enum logic [1:0] {
    LOCK_OFF      = 2'b00,
    LOCK_SOFT     = 2'b01,
    LOCK_OFF_ALT  = 2'b10,
    LOCK_HARD     = 2'b11
  } lockMode_e;

  typedef struct packed {
    logic forceIdle;
    logic reloadDuty;
  } lockStrobe_t;

  localparam logic [1:0] ADDR_ACTIVE  = 2'd0;
  localparam logic [1:0] ADDR_PENDING = 2'd1;
  localparam logic [1:0] ADDR_PERIOD  = 2'd2;
  localparam logic [1:0] ADDR_CTRL    = 2'd3;

  localparam int CTRL_POL_BIT     = 0;
  localparam int CTRL_RELEASE_BIT = 1;
  localparam int CTRL_MODE_LSB    = 2;

endpackage

// File: rtl/pwmlock_edge.sv
module pwmlock_edge #(
  parameter int NUM_CH      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] cmpIn,
  output logic [NUM_CH-1:0] fallPulse
);

  // Inputs idle high; the chain resets high so reset release makes no edge.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [SYNC_STAGES:0] chain;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        chain <= '1;
      end else begin
        chain <= {chain[SYNC_STAGES-1:0], cmpIn[ch]};
      end
    end

    // chain[SYNC_STAGES-1] is the synchronized level; chain[SYNC_STAGES] is its previous value.
    assign fallPulse[ch] = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
  end

endmodule

// File: rtl/pwmlock_ctrl.sv
module pwmlock_ctrl
  import pwmlock_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_CH-1:0]   fallPulse,
  input  logic [2*NUM_CH-1:0] modeBits,
  input  logic                unlockWr,
  input  logic                periodWrap,
  output lockStrobe_t         strobe,
  output logic                hardLock,
  output logic                softLock,
  output logic                trigHard,
  output logic                trigSoft
);

  logic [NUM_CH-1:0] hardHit;
  logic [NUM_CH-1:0] softHit;
  logic              softArm;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    lockMode_e chMode;
    assign chMode      = lockMode_e'(modeBits[2*ch +: 2]);
    assign hardHit[ch] = fallPulse[ch] && (chMode == LOCK_HARD);
    assign softHit[ch] = fallPulse[ch] && (chMode == LOCK_SOFT);
  end

  assign trigHard = |hardHit;
  assign trigSoft = |softHit;
  // Hard trigger takes priority: a simultaneous soft trigger is dropped.
  assign softArm  = trigSoft && !trigHard;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hardLock <= 1'b0;
    end else if (trigHard) begin
      hardLock <= 1'b1;
    end else if (unlockWr) begin
      hardLock <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softLock <= 1'b0;
    end else if (softArm) begin
      softLock <= 1'b1;
    end else if (periodWrap) begin
      softLock <= 1'b0;
    end
  end

  always_comb begin
    strobe.forceIdle  = hardLock || softLock || trigHard || softArm;
    strobe.reloadDuty = softArm;
  end

endmodule

// File: rtl/pwmlock_dp.sv
module pwmlock_dp
  import pwmlock_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 16,
  parameter int NUM_CH = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          wrAddr,
  input  logic [BUS_W-1:0]    wrData,
  input  logic [1:0]          rdAddr,
  input  lockStrobe_t         strobe,
  output logic [BUS_W-1:0]    rdData,
  output logic                pwmOut,
  output logic [DATA_W-1:0]   activeDuty,
  output logic [DATA_W-1:0]   pendingDuty,
  output logic                polarity,
  output logic [2*NUM_CH-1:0] modeBits,
  output logic                unlockWr,
  output logic                periodWrap
);

  localparam int CTRL_W = CTRL_MODE_LSB + 2*NUM_CH;

  logic [DATA_W-1:0] periodReg;
  logic [DATA_W-1:0] cnt;
  logic [CTRL_W-1:0] ctrlReg;
  logic              wrActive;
  logic              wrPending;
  logic              wrPeriod;
  logic              wrCtrl;
  logic              rawHigh;

  assign wrActive  = wrEn && (wrAddr == ADDR_ACTIVE);
  assign wrPending = wrEn && (wrAddr == ADDR_PENDING);
  assign wrPeriod  = wrEn && (wrAddr == ADDR_PERIOD);
  assign wrCtrl    = wrEn && (wrAddr == ADDR_CTRL);
  assign unlockWr  = wrCtrl && wrData[CTRL_RELEASE_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeDuty <= '0;
    end else if (strobe.reloadDuty) begin
      activeDuty <= pendingDuty;
    end else if (wrActive) begin
      activeDuty <= wrData[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingDuty <= '0;
      periodReg   <= '0;
      ctrlReg     <= '0;
    end else begin
      if (wrPending) pendingDuty <= wrData[DATA_W-1:0];
      if (wrPeriod)  periodReg   <= wrData[DATA_W-1:0];
      // The release bit is an action, never stored.
      if (wrCtrl)    ctrlReg     <= {wrData[CTRL_W-1:CTRL_MODE_LSB], 1'b0, wrData[CTRL_POL_BIT]};
    end
  end

  // The counter runs through locks so that soft release lines up with the wrap.
  assign periodWrap = (cnt >= periodReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (periodWrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign polarity = ctrlReg[CTRL_POL_BIT];
  assign modeBits = ctrlReg[CTRL_W-1:CTRL_MODE_LSB];
  assign rawHigh  = (cnt < activeDuty);
  assign pwmOut   = strobe.forceIdle ? polarity : (polarity ^ rawHigh);

  always_comb begin
    unique case (rdAddr)
      ADDR_ACTIVE:  rdData = BUS_W'(activeDuty);
      ADDR_PENDING: rdData = BUS_W'(pendingDuty);
      ADDR_PERIOD:  rdData = BUS_W'(periodReg);
      default:      rdData = BUS_W'(ctrlReg);
    endcase
  end

endmodule

// File: rtl/pwmlock_top.sv
module pwmlock_top
  import pwmlock_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int DATA_W      = 8,
  parameter int BUS_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic [1:0]        rdAddr,
  output logic [BUS_W-1:0]  rdData,
  input  logic [NUM_CH-1:0] cmpIn,
  output logic              pwmOut
);

  logic [NUM_CH-1:0]   fallPulse;
  logic [2*NUM_CH-1:0] modeBits;
  logic                unlockWr;
  logic                periodWrap;
  logic                hardLock;
  logic                softLock;
  logic                trigHard;
  logic                trigSoft;
  logic                polarity;
  logic [DATA_W-1:0]   activeDuty;
  logic [DATA_W-1:0]   pendingDuty;
  lockStrobe_t         strobe;

  pwmlock_edge #(
    .NUM_CH      (NUM_CH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rstN      (rstN),
    .cmpIn     (cmpIn),
    .fallPulse (fallPulse)
  );

  pwmlock_ctrl #(
    .NUM_CH (NUM_CH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .fallPulse  (fallPulse),
    .modeBits   (modeBits),
    .unlockWr   (unlockWr),
    .periodWrap (periodWrap),
    .strobe     (strobe),
    .hardLock   (hardLock),
    .softLock   (softLock),
    .trigHard   (trigHard),
    .trigSoft   (trigSoft)
  );

  pwmlock_dp #(
    .DATA_W (DATA_W),
    .BUS_W  (BUS_W),
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .strobe      (strobe),
    .rdData      (rdData),
    .pwmOut      (pwmOut),
    .activeDuty  (activeDuty),
    .pendingDuty (pendingDuty),
    .polarity    (polarity),
    .modeBits    (modeBits),
    .unlockWr    (unlockWr),
    .periodWrap  (periodWrap)
  );

endmodule

// File: rtl/pwmlock_checker.sv
module pwmlock_checker #(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              hardLock,
  input logic              softLock,
  input logic              trigHard,
  input logic              trigSoft,
  input logic              unlockWr,
  input logic              periodWrap,
  input logic              polarity,
  input logic              pwmOut,
  input logic [DATA_W-1:0] activeDuty,
  input logic [DATA_W-1:0] pendingDuty,
  input logic [1:0]        rdAddr,
  input logic [BUS_W-1:0]  rdData
);

  AST_LOCK_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (hardLock || softLock || trigHard) |-> (pwmOut == polarity)); // R3

  AST_HARD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (hardLock && !unlockWr) |=> hardLock); // R5

  AST_HARD_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (unlockWr && !trigHard) |=> !hardLock); // R5

  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (trigSoft && !trigHard) |=> (activeDuty == $past(pendingDuty))); // R6

  AST_SOFT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (softLock && periodWrap && !trigSoft) |=> !softLock); // R7

  AST_RELEASE_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd3) |-> (rdData[1] == 1'b0)); // R8

  AST_HARD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (trigHard && trigSoft && !softLock) |=> (hardLock && !softLock)); // R9

  AST_HARD_NO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (trigHard && trigSoft) |=> $stable(activeDuty)); // R9

endmodule

bind pwmlock_top pwmlock_checker #(
  .DATA_W (DATA_W),
  .BUS_W  (BUS_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .hardLock    (hardLock),
  .softLock    (softLock),
  .trigHard    (trigHard),
  .trigSoft    (trigSoft),
  .unlockWr    (unlockWr),
  .periodWrap  (periodWrap),
  .polarity    (polarity),
  .pwmOut      (pwmOut),
  .activeDuty  (activeDuty),
  .pendingDuty (pendingDuty),
  .rdAddr      (rdAddr),
  .rdData      (rdData)
);

// File: tb/tb_pwmlock_top.sv
`timescale 1ns/1ps
module tb_pwmlock_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [1:0]  wrAddr;
  logic [15:0] wrData;
  logic [1:0]  rdAddr;
  logic [15:0] rdData;
  logic [2:0]  cmpIn;
  logic        pwmOut;

  int checks = 0;
  int fails  = 0;
  int mCnt;
  int mPer;

  always #2 clk = ~clk;

  pwmlock_top dut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cmpIn  (cmpIn),
    .pwmOut (pwmOut)
  );

  // Arithmetic phase model of the counter, from R2.
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt <= 0;
      mPer <= 0;
    end else begin
      mCnt <= (mCnt >= mPer) ? 0 : mCnt + 1;
      if (wrEn && wrAddr == 2'd2) mPer <= int'(wrData[7:0]);
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  function automatic int normExp(input int duty, input int pol);
    return pol ^ ((mCnt < duty) ? 1 : 0);
  endfunction

  initial begin
    int v;
    int lk;
    int first;
    int prev;
    int ex;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0; cmpIn = 3'b111;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1", v, 0);
    end
    check(pwmOut == 1'b0, "R1", int'(pwmOut), 0);

    // R2: sweep polarity, period and duty
    for (int pol = 0; pol < 2; pol++)
      for (int per = 0; per < 5; per++)
        for (int duty = 0; duty < 7; duty++) begin
          wr(2'd3, 16'(pol));
          wr(2'd2, 16'(per));
          wr(2'd0, 16'(duty));
          for (int i = 0; i < 2*(per+1); i++) begin
            @(negedge clk);
            ex = normExp(duty, pol);
            check(int'(pwmOut) == ex, "R2", int'(pwmOut), ex);
          end
        end

    // R4: modes 10 (ch1) and 00 (ch2) ignore falling edges
    wr(2'd3, 16'h0020);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'd2);
    cmpIn[1] = 1'b0; cmpIn[2] = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      ex = normExp(2, 0);
      check(int'(pwmOut) == ex, "R4", int'(pwmOut), ex);
    end

    // R10: rising edge on a hard-lock channel does nothing
    wr(2'd3, 16'h00C0);
    cmpIn[1] = 1'b1; cmpIn[2] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ex = normExp(2, 0);
      check(int'(pwmOut) == ex, "R10", int'(pwmOut), ex);
    end

    // R3 / R5: hard lock on ch2 with polarity 1
    wr(2'd3, 16'h00C1);
    @(negedge clk);
    cmpIn[2] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(pwmOut == 1'b1, "R3", int'(pwmOut), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i == 5) cmpIn[2] = 1'b1;
      check(pwmOut == 1'b1, "R5", int'(pwmOut), 1);
    end
    wr(2'd3, 16'h00C3);
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      ex = normExp(2, 1);
      check(int'(pwmOut) == ex, "R5", int'(pwmOut), ex);
    end
    // R8: release bit reads back as 0, other bits kept
    rd(2'd3, v);
    check(v == 16'h00C1, "R8", v, 16'h00C1);

    // R6 / R7: soft lock on ch0 at every counter phase
    wr(2'd3, 16'h0004);
    wr(2'd2, 16'd7);
    wr(2'd1, 16'd5);
    for (int ph = 0; ph < 8; ph++) begin
      wr(2'd0, 16'd1);
      while (mCnt != ph) @(negedge clk);
      cmpIn[0] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(pwmOut == 1'b0, "R3", int'(pwmOut), 0);
      lk = 1; first = 1; prev = mCnt;
      for (int i = 0; i < 18; i++) begin
        @(negedge clk);
        if (first == 0 && prev >= 7) lk = 0;
        first = 0; prev = mCnt;
        ex = (lk != 0) ? 0 : normExp(5, 0);
        check(int'(pwmOut) == ex, "R7", int'(pwmOut), ex);
        if (i == 0) begin
          rd(2'd0, v);
          check(v == 5, "R6", v, 5);
        end
      end
      cmpIn[0] = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R9: simultaneous soft (ch0) and hard (ch1) triggers
    wr(2'd3, 16'h0034);
    wr(2'd2, 16'd3);
    wr(2'd0, 16'd2);
    wr(2'd1, 16'd6);
    cmpIn[0] = 1'b0; cmpIn[1] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      check(pwmOut == 1'b0, "R9", int'(pwmOut), 0);
      @(negedge clk);
    end
    rd(2'd0, v);
    check(v == 2, "R9", v, 2);
    wr(2'd3, 16'h0036);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      ex = normExp(2, 0);
      check(int'(pwmOut) == ex, "R9", int'(pwmOut), ex);
    end
    cmpIn = 3'b111;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule